// File: doc/BRIEF.md
# Linked-List Multi-Channel DMA Engine

This block moves memory regions on behalf of software without per-transfer CPU attention. Each of its channels is started with a pointer to the first entry of a chain of transfer descriptors in memory. The engine reads each descriptor through a single-outstanding read port. It then breaks the requested move into write bursts and follows the link to the next descriptor. A null link ends the chain, and the engine raises a one-cycle completion pulse. A downstream mover carries out each burst; the engine only produces the burst commands (source, destination, byte count).

A descriptor describes either one contiguous region or a block-stride pattern. In the block-stride pattern, a number of equal blocks are moved, and the start of each block on one side jumps by a fixed stride while the other side stays packed. All channels share the read port and the burst output. The burst output is arbitrated round-robin one burst at a time, so a long chain on one channel cannot starve the others. No burst exceeds 256 bytes, and no burst crosses a 4 KB destination boundary.

Top module: `chain_dma`

## Requirements
- R1: A descriptor is five 64-bit words at consecutive 8-byte addresses starting at its pointer: word 0 source address, word 1 destination address, word 2 byte length (low 32 bits used), word 3 flags, word 4 next pointer. The read request holds a fixed address until `rd_valid_i` returns that word.
- R2: `status_o[3c+:3]` encodes channel c as 0 idle, 1 fetching, 2 transferring, 3 done, 4 error. A `start_i[c]` pulse in idle, done or error loads `head_ptr_i[64c+:64]` and begins fetching. A pulse while the channel is fetching or transferring is ignored.
- R3: A contiguous descriptor is moved as bursts with ascending source and destination addresses whose lengths sum exactly to the descriptor length.
- R4: Every burst carries between 1 and 256 bytes, and a region longer than 256 bytes is split into 256-byte bursts followed by the remainder.
- R5: No burst crosses a 4 KB destination boundary. A burst that would cross is cut at the boundary and the rest follows in the next burst.
- R6: After the descriptor with a zero next pointer finishes, the channel pulses `done_o[c]` for one cycle and reports done. A non-zero next pointer is fetched and executed with no completion pulse in between.
- R7: Flags bit 0 selects block-stride mode. Bits [31:16] give the block count, the length gives the block size, and bits [63:32] give the stride in bytes. Bit 2 selects the strided side (0 source, 1 destination), and the other side continues contiguously.
- R8: Each of these puts the channel in error with no burst issued from the offending descriptor: zero length, zero block count in stride mode, or a head or next pointer with non-zero bits [2:0]. Other channels carry on unaffected.
- R9: Channels with pending bursts are served round-robin one burst at a time. A burst offered while `wr_ready_i` is low stays unchanged until it is accepted.
- R10: `irq_o[c]` pulses together with `done_o[c]` only when flags bit 1 of the final descriptor is set.
- R11: After reset, every channel is idle and no read request, burst or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | NCH | Per-channel start pulse |
| head_ptr_i | input | NCH*AW | Per-channel first descriptor address |
| status_o | output | NCH*3 | Per-channel state code |
| done_o | output | NCH | Chain completion pulse |
| irq_o | output | NCH | Interrupt pulse on flagged completion |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | AW | Descriptor word address |
| rd_valid_i | input | 1 | Read word returned |
| rd_data_i | input | 64 | Read word |
| wr_valid_o | output | 1 | Burst command valid |
| wr_ready_i | input | 1 | Burst command accepted |
| wr_ch_o | output | CW | Channel owning the burst |
| wr_src_o | output | AW | Burst source address |
| wr_dst_o | output | AW | Burst destination address |
| wr_len_o | output | BW | Burst byte count |

## Verification
The assertions check the following on every cycle:
- the burst size bound and the 4 KB boundary rule;
- that a stalled burst and a pending read stay frozen;
- that completion only follows a transfer, with the interrupt tied to it;
- that error is sticky until a new start.

The directed scenarios are needed for the behaviour that depends on whole sequences:
- exact burst address and length sequences for contiguous, page-cut and both stride directions;
- chain following and the descriptor read addresses;
- each error cause;
- the alternating channel order once a stalled output is released.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_DONE  = 3'd3,
    ST_ERR   = 3'd4
  } ch_state_e;

  localparam int DESC_WORDS = 5;
  localparam int F_STRIDE   = 0;
  localparam int F_IRQ      = 1;
  localparam int F_SDST     = 2;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] len;
    logic [63:0] flags;
    logic [63:0] nxt;
  } desc_t;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  input  logic [IW-1:0] adv_idx_i,
  output logic          any_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;

  // search starts one past the last served index
  always_comb begin
    any_o     = 1'b0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any_o && req_i[(int'(last_q) + k) % N]) begin
        any_o     = 1'b1;
        gnt_idx_o = IW'((int'(last_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(N - 1);
    else if (adv_i) last_q <= adv_idx_i;
  end
endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc #(
  parameter int LW        = 32,
  parameter int MAX_BURST = 256,
  parameter int PAGE      = 4096,
  parameter int PW        = $clog2(PAGE),
  parameter int BW        = $clog2(MAX_BURST) + 1
) (
  input  logic [PW-1:0] dst_off_i,
  input  logic [LW-1:0] left_i,
  output logic [BW-1:0] len_o
);
  logic [LW-1:0] to_page;
  logic [LW-1:0] lim;

  assign to_page = LW'(PAGE) - LW'(dst_off_i);

  always_comb begin
    lim = LW'(MAX_BURST);
    if (to_page < lim) lim = to_page;
    if (left_i < lim)  lim = left_i;
    len_o = BW'(lim);
  end
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 64,
  parameter int CW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*AW-1:0] ptr_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [63:0]       rd_data_i,
  output logic              desc_vld_o,
  output logic [CW-1:0]     desc_ch_o,
  output desc_t             desc_o
);
  logic          busy_q, vld_q, grab, arb_any;
  logic [CW-1:0] ch_q, arb_idx;
  logic [AW-1:0] base_q;
  logic [2:0]    wcnt_q;
  logic [63:0]   w_q [DESC_WORDS];

  // hold off while the finished descriptor is being consumed
  assign grab = arb_any && !busy_q && !vld_q;

  dma_rr_arb #(.N(NCH), .IW(CW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .adv_i     (grab),
    .adv_idx_i (arb_idx),
    .any_o     (arb_any),
    .gnt_idx_o (arb_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      ch_q   <= '0;
      base_q <= '0;
      wcnt_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) w_q[i] <= '0;
    end else begin
      vld_q <= 1'b0;
      if (grab) begin
        busy_q <= 1'b1;
        ch_q   <= arb_idx;
        base_q <= ptr_i[int'(arb_idx)*AW +: AW];
        wcnt_q <= '0;
      end else if (busy_q && rd_valid_i) begin
        case (wcnt_q)
          3'd0:    w_q[0] <= rd_data_i;
          3'd1:    w_q[1] <= rd_data_i;
          3'd2:    w_q[2] <= rd_data_i;
          3'd3:    w_q[3] <= rd_data_i;
          default: w_q[4] <= rd_data_i;
        endcase
        if (wcnt_q == 3'(DESC_WORDS - 1)) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
        end else begin
          wcnt_q <= wcnt_q + 3'd1;
        end
      end
    end
  end

  assign rd_req_o   = busy_q;
  assign rd_addr_o  = base_q + AW'({wcnt_q, 3'b000});
  assign desc_vld_o = vld_q;
  assign desc_ch_o  = ch_q;
  assign desc_o     = '{src: w_q[0], dst: w_q[1], len: w_q[2], flags: w_q[3], nxt: w_q[4]};

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o)) else $error("rd hold"); // R1
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import dma_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 64,
  parameter int LW        = 32,
  parameter int MAX_BURST = 256,
  parameter int PAGE      = 4096,
  parameter int CW        = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int BW        = $clog2(MAX_BURST) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    start_i,
  input  logic [NCH*AW-1:0] head_ptr_i,
  output logic [NCH*3-1:0]  status_o,
  output logic [NCH-1:0]    done_o,
  output logic [NCH-1:0]    irq_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [63:0]       rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [CW-1:0]     wr_ch_o,
  output logic [AW-1:0]     wr_src_o,
  output logic [AW-1:0]     wr_dst_o,
  output logic [BW-1:0]     wr_len_o
);
  localparam int PW = $clog2(PAGE);

  ch_state_e     st_q     [NCH];
  logic [AW-1:0] src_q    [NCH];
  logic [AW-1:0] dst_q    [NCH];
  logic [AW-1:0] bsrc_q   [NCH];
  logic [AW-1:0] bdst_q   [NCH];
  logic [AW-1:0] nxt_q    [NCH];
  logic [LW-1:0] left_q   [NCH];
  logic [LW-1:0] bsize_q  [NCH];
  logic [15:0]   nblk_q   [NCH];
  logic [31:0]   stride_q [NCH];
  logic          sdst_q   [NCH];
  logic          irqen_q  [NCH];
  logic          done_q   [NCH];
  logic          irq_q    [NCH];

  logic [NCH-1:0]    fetch_req, xfer_req;
  logic [NCH*AW-1:0] ptr_flat;
  logic              desc_vld;
  logic [CW-1:0]     desc_ch;
  desc_t             desc;
  logic              desc_bad;
  logic              unused_desc;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      fetch_req[c]          = (st_q[c] == ST_FETCH);
      xfer_req[c]           = (st_q[c] == ST_XFER);
      ptr_flat[c*AW +: AW]  = nxt_q[c];
      status_o[c*3 +: 3]    = st_q[c];
      done_o[c]             = done_q[c];
      irq_o[c]              = irq_q[c];
    end
  end

  dma_desc_fetch #(.NCH(NCH), .AW(AW), .CW(CW)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (fetch_req),
    .ptr_i      (ptr_flat),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .desc_vld_o (desc_vld),
    .desc_ch_o  (desc_ch),
    .desc_o     (desc)
  );

  assign desc_bad = (desc.len[LW-1:0] == '0)
                 || (desc.flags[F_STRIDE] && desc.flags[31:16] == 16'd0)
                 || (desc.nxt[2:0] != 3'd0);
  assign unused_desc = ^{desc.len[63:LW], desc.flags[15:3]};

  // burst output: grant is frozen while a stalled burst waits
  logic          hold_q, arb_any, hs;
  logic [CW-1:0] hold_ch_q, arb_idx, gsel;
  logic [BW-1:0] blen;

  dma_rr_arb #(.N(NCH), .IW(CW)) u_wr_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (xfer_req),
    .adv_i     (hs),
    .adv_idx_i (gsel),
    .any_o     (arb_any),
    .gnt_idx_o (arb_idx)
  );

  assign gsel       = hold_q ? hold_ch_q : arb_idx;
  assign wr_valid_o = hold_q | arb_any;
  assign hs         = wr_valid_o && wr_ready_i;

  dma_burst_calc #(.LW(LW), .MAX_BURST(MAX_BURST), .PAGE(PAGE), .PW(PW), .BW(BW)) u_calc (
    .dst_off_i (dst_q[gsel][PW-1:0]),
    .left_i    (left_q[gsel]),
    .len_o     (blen)
  );

  assign wr_ch_o  = gsel;
  assign wr_src_o = src_q[gsel];
  assign wr_dst_o = dst_q[gsel];
  assign wr_len_o = blen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else if (hs) begin
      hold_q    <= 1'b0;
    end else if (wr_valid_o) begin
      hold_q    <= 1'b1;
      hold_ch_q <= gsel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        st_q[c]     <= ST_IDLE;
        src_q[c]    <= '0;
        dst_q[c]    <= '0;
        bsrc_q[c]   <= '0;
        bdst_q[c]   <= '0;
        nxt_q[c]    <= '0;
        left_q[c]   <= '0;
        bsize_q[c]  <= '0;
        nblk_q[c]   <= '0;
        stride_q[c] <= '0;
        sdst_q[c]   <= 1'b0;
        irqen_q[c]  <= 1'b0;
        done_q[c]   <= 1'b0;
        irq_q[c]    <= 1'b0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        done_q[c] <= 1'b0;
        irq_q[c]  <= 1'b0;
        case (st_q[c])
          ST_FETCH: begin
            if (desc_vld && int'(desc_ch) == c) begin
              if (desc_bad) begin
                st_q[c] <= ST_ERR;
              end else begin
                st_q[c]     <= ST_XFER;
                src_q[c]    <= desc.src[AW-1:0];
                bsrc_q[c]   <= desc.src[AW-1:0];
                dst_q[c]    <= desc.dst[AW-1:0];
                bdst_q[c]   <= desc.dst[AW-1:0];
                left_q[c]   <= desc.len[LW-1:0];
                bsize_q[c]  <= desc.len[LW-1:0];
                nblk_q[c]   <= desc.flags[F_STRIDE] ? desc.flags[31:16] : 16'd1;
                stride_q[c] <= desc.flags[63:32];
                sdst_q[c]   <= desc.flags[F_SDST];
                irqen_q[c]  <= desc.flags[F_IRQ];
                nxt_q[c]    <= desc.nxt[AW-1:0];
              end
            end
          end
          ST_XFER: begin
            if (hs && int'(gsel) == c) begin
              src_q[c] <= src_q[c] + AW'(blen);
              dst_q[c] <= dst_q[c] + AW'(blen);
              if (left_q[c] == LW'(blen)) begin
                if (nblk_q[c] == 16'd1) begin
                  if (nxt_q[c] == '0) begin
                    st_q[c]   <= ST_DONE;
                    done_q[c] <= 1'b1;
                    irq_q[c]  <= irqen_q[c];
                  end else begin
                    st_q[c]   <= ST_FETCH;
                  end
                end else begin
                  nblk_q[c] <= nblk_q[c] - 16'd1;
                  left_q[c] <= bsize_q[c];
                  if (sdst_q[c]) begin
                    bdst_q[c] <= bdst_q[c] + AW'(stride_q[c]);
                    dst_q[c]  <= bdst_q[c] + AW'(stride_q[c]);
                  end else begin
                    bsrc_q[c] <= bsrc_q[c] + AW'(stride_q[c]);
                    src_q[c]  <= bsrc_q[c] + AW'(stride_q[c]);
                  end
                end
              end else begin
                left_q[c] <= left_q[c] - LW'(blen);
              end
            end
          end
          default: begin
            if (start_i[c]) begin
              if (head_ptr_i[c*AW +: 3] != 3'd0) begin
                st_q[c]  <= ST_ERR;
              end else begin
                st_q[c]  <= ST_FETCH;
                nxt_q[c] <= head_ptr_i[c*AW +: AW];
              end
            end
          end
        endcase
      end
    end
  end

  AST_BURST_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_len_o != '0 && int'(wr_len_o) <= MAX_BURST) else $error("burst size"); // R4
  AST_NO_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> int'(wr_dst_o[PW-1:0]) + int'(wr_len_o) <= PAGE) else $error("page cross"); // R5
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_ch_o) && $stable(wr_dst_o)
                                  && $stable(wr_src_o) && $stable(wr_len_o)) else $error("hold"); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_DONE_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[g] |-> $past(st_q[g]) == ST_XFER && st_q[g] == ST_DONE) else $error("done"); // R6
    AST_IRQ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> done_o[g]) else $error("irq"); // R10
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_q[g] == ST_ERR && !start_i[g] |=> st_q[g] == ST_ERR) else $error("err"); // R8
  end
endmodule

// File: tb/chain_dma_bench.sv
`timescale 1ns/1ps
module chain_dma_bench;
  localparam int NCH = 4;
  localparam int AW  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    start = '0;
  logic [NCH*AW-1:0] head = '0;
  logic [NCH*3-1:0]  status;
  logic [NCH-1:0]    done, irq;
  logic              rd_req, rd_valid = 1'b0;
  logic [AW-1:0]     rd_addr;
  logic [63:0]       rd_data = '0;
  logic              wr_valid, wr_ready = 1'b1;
  logic [1:0]        wr_ch;
  logic [AW-1:0]     wr_src, wr_dst;
  logic [8:0]        wr_len;

  chain_dma u_chain_dma (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_ptr_i(head),
    .status_o(status), .done_o(done), .irq_o(irq),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_ch_o(wr_ch),
    .wr_src_o(wr_src), .wr_dst_o(wr_dst), .wr_len_o(wr_len)
  );

  always #2.5 clk = ~clk;

  logic [63:0] mem [0:255];
  longint unsigned rlog [0:63];
  longint unsigned bsrc [0:63], bdst [0:63];
  int bch [0:63], blen [0:63];
  int rn = 0, bn = 0;
  int dcnt [NCH], icnt [NCH];
  int n_chk = 0, n_fail = 0;

  // descriptor memory: one word per request, answered the cycle after
  always @(posedge clk) begin
    #1;
    if (!rst_n) rd_valid = 1'b0;
    else if (rd_req && !rd_valid) begin
      rd_valid = 1'b1;
      rd_data  = mem[rd_addr[10:3]];
      if (rn < 64) rlog[rn] = rd_addr;
      rn++;
    end else rd_valid = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (bn < 64) begin
          bch[bn] = int'(wr_ch); bsrc[bn] = wr_src; bdst[bn] = wr_dst; blen[bn] = int'(wr_len);
        end
        bn++;
      end
      for (int c = 0; c < NCH; c++) begin
        if (done[c]) dcnt[c]++;
        if (irq[c])  icnt[c]++;
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_burst(input string tag, input int i, input int ch,
                           input longint unsigned s, input longint unsigned d, input int l);
    chk({tag, " ch"}, bch[i], ch);
    chk({tag, " src"}, bsrc[i], s);
    chk({tag, " dst"}, bdst[i], d);
    chk({tag, " len"}, blen[i], l);
  endtask

  task automatic put_desc(input int a, input longint unsigned s, input longint unsigned d,
                          input longint unsigned l, input longint unsigned f, input longint unsigned n);
    mem[(a >> 3) + 0] = s; mem[(a >> 3) + 1] = d; mem[(a >> 3) + 2] = l;
    mem[(a >> 3) + 3] = f; mem[(a >> 3) + 4] = n;
  endtask

  task automatic clear_logs();
    rn = 0; bn = 0;
    for (int c = 0; c < NCH; c++) begin dcnt[c] = 0; icnt[c] = 0; end
  endtask

  task automatic kick(input logic [NCH-1:0] mask);
    @(posedge clk); #1;
    start = mask;
    @(posedge clk); #1;
    start = '0;
  endtask

  task automatic set_head(input int c, input longint unsigned h);
    head[c*AW +: AW] = h;
  endtask

  task automatic wait_state(input int c, input int s);
    int t = 0;
    while (t < 3000 && int'(status[c*3 +: 3]) != s) begin @(negedge clk); t++; end
    if (t >= 3000) chk("timeout state", status[c*3 +: 3], s);
  endtask

  task automatic wait_end(input int c);
    int t = 0;
    while (t < 3000 && status[c*3 +: 3] < 3'd3) begin @(negedge clk); t++; end
    if (t >= 3000) chk("timeout end", status[c*3 +: 3], 3);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 status", status, 0);
    chk("R11 wr_valid", wr_valid, 0);
    chk("R11 rd_req", rd_req, 0);
    chk("R11 done", done, 0);
  endtask

  task automatic t_contig();
    clear_logs();
    put_desc(32'h40, 64'h1000, 64'h2000, 600, 0, 0);
    put_desc(32'h200, 64'h0, 64'h0, 0, 0, 0);
    set_head(0, 64'h40);
    kick(4'b0001);
    wait_state(0, 1);
    chk("R2 fetching", status[2:0], 1);
    set_head(0, 64'h200);   // must be ignored while busy
    kick(4'b0001);
    wait_end(0);
    chk("R1 reads", rn, 5);
    for (int i = 0; i < 5; i++) chk("R1 read addr", rlog[i], 64'h40 + 8*i);
    chk("R3 bursts", bn, 3);
    chk_burst("R4 b0", 0, 0, 64'h1000, 64'h2000, 256);
    chk_burst("R4 b1", 1, 0, 64'h1100, 64'h2100, 256);
    chk_burst("R3 b2", 2, 0, 64'h1200, 64'h2200, 88);
    chk("R2 busy start ignored", status[2:0], 3);
    chk("R6 done count", dcnt[0], 1);
    chk("R10 no irq", icnt[0], 0);
  endtask

  task automatic t_page();
    clear_logs();
    put_desc(32'h80, 64'h5000, 64'h2F80, 300, 0, 0);
    set_head(1, 64'h80);
    kick(4'b0010);
    wait_end(1);
    chk("R5 bursts", bn, 2);
    chk_burst("R5 b0", 0, 1, 64'h5000, 64'h2F80, 128);
    chk_burst("R5 b1", 1, 1, 64'h5080, 64'h3000, 172);
  endtask

  task automatic t_chain();
    clear_logs();
    put_desc(32'hC0, 64'h100, 64'h400, 16, 0, 64'h140);
    put_desc(32'h140, 64'h700, 64'h800, 32, 0, 0);
    set_head(2, 64'hC0);
    kick(4'b0100);
    wait_end(2);
    chk("R1 chain reads", rn, 10);
    chk("R1 second desc addr", rlog[5], 64'h140);
    chk("R6 bursts", bn, 2);
    chk_burst("R6 b0", 0, 2, 64'h100, 64'h400, 16);
    chk_burst("R6 b1", 1, 2, 64'h700, 64'h800, 32);
    chk("R6 single done", dcnt[2], 1);
    chk("R6 status", status[8:6], 3);
  endtask

  task automatic t_stride_src();
    clear_logs();
    put_desc(32'h180, 64'h8000, 64'h9000, 64, 64'h1 | 64'h2 | (64'd3 << 16) | (64'h100 << 32), 0);
    set_head(3, 64'h180);
    kick(4'b1000);
    wait_end(3);
    chk("R7 bursts", bn, 3);
    chk_burst("R7 s0", 0, 3, 64'h8000, 64'h9000, 64);
    chk_burst("R7 s1", 1, 3, 64'h8100, 64'h9040, 64);
    chk_burst("R7 s2", 2, 3, 64'h8200, 64'h9080, 64);
    chk("R10 irq", icnt[3], 1);
    chk("R10 done", dcnt[3], 1);
  endtask

  task automatic t_stride_dst();
    clear_logs();
    put_desc(32'h1C0, 64'hB000, 64'hA000, 300, 64'h1 | 64'h4 | (64'd2 << 16) | (64'h400 << 32), 0);
    set_head(0, 64'h1C0);
    kick(4'b0001);
    wait_end(0);
    chk("R7 dst bursts", bn, 4);
    chk_burst("R7 d0", 0, 0, 64'hB000, 64'hA000, 256);
    chk_burst("R7 d1", 1, 0, 64'hB100, 64'hA100, 44);
    chk_burst("R7 d2", 2, 0, 64'hB12C, 64'hA400, 256);
    chk_burst("R7 d3", 3, 0, 64'hB22C, 64'hA500, 44);
  endtask

  task automatic t_errors();
    clear_logs();
    set_head(1, 64'h200);
    kick(4'b0010);
    wait_end(1);
    chk("R8 zero len status", status[5:3], 4);
    chk("R8 zero len bursts", bn, 0);
    clear_logs();
    set_head(1, 64'h204);
    kick(4'b0010);
    wait_end(1);
    chk("R8 bad head status", status[5:3], 4);
    chk("R8 bad head reads", rn, 0);
    clear_logs();
    put_desc(32'h240, 64'h100, 64'h200, 8, 0, 64'h283);
    set_head(2, 64'h240);
    kick(4'b0100);
    wait_end(2);
    chk("R8 bad next status", status[8:6], 4);
    chk("R8 bad next bursts", bn, 0);
    clear_logs();
    put_desc(32'h280, 64'h100, 64'h200, 8, 64'h1, 0);
    set_head(2, 64'h280);
    kick(4'b0100);
    wait_end(2);
    chk("R8 zero count status", status[8:6], 4);
    chk("R8 zero count bursts", bn, 0);
  endtask

  task automatic t_round_robin();
    int first;
    clear_logs();
    put_desc(32'h2C0, 64'h10000, 64'h20000, 512, 0, 0);
    put_desc(32'h300, 64'h30000, 64'h40000, 512, 0, 0);
    @(posedge clk); #1; wr_ready = 1'b0;
    set_head(0, 64'h2C0);
    set_head(1, 64'h300);
    set_head(2, 64'h305);
    kick(4'b0111);
    wait_state(0, 2);
    wait_state(1, 2);
    first = int'(wr_ch);
    repeat (3) @(negedge clk);
    chk("R9 held valid", wr_valid, 1);
    chk("R9 held channel", wr_ch, first);
    @(posedge clk); #1; wr_ready = 1'b1;
    wait_end(0);
    wait_end(1);
    chk("R9 bursts", bn, 4);
    chk("R9 first", bch[0], first);
    chk("R9 alternate 1", bch[1], 1 - first);
    chk("R9 alternate 2", bch[2], first);
    chk("R9 alternate 3", bch[3], 1 - first);
    for (int i = 0; i < 4; i++) begin
      longint unsigned s0 = (bch[i] == 0) ? 64'h10000 : 64'h30000;
      longint unsigned d0 = (bch[i] == 0) ? 64'h20000 : 64'h40000;
      chk("R9 src", bsrc[i], s0 + ((i >= 2) ? 256 : 0));
      chk("R9 dst", bdst[i], d0 + ((i >= 2) ? 256 : 0));
    end
    chk("R8 other ch err", status[8:6], 4);
    chk("R8 ch0 unaffected", status[2:0], 3);
    chk("R8 ch1 unaffected", status[5:3], 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clear_logs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_contig();
    t_page();
    t_chain();
    t_stride_src();
    t_stride_dst();
    t_errors();
    t_round_robin();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule